// File: doc/BRIEF.md
# Video Mode Reference Clock Generator

This block turns a 20.2752 MHz master clock into the reference signals that a four-format text video timing chain needs. It makes three signals. The first is a half-rate dot reference of 10.1376 MHz, used by the 64- and 32-column formats. The second is a 1.2672 MHz square wave, made by dividing the master by 16, which goes out to an external PLL multiplier. The third comes from the PLL's 12.672 MHz output when it returns to the block: a divide-by-ten gives a second 1.2672 MHz square wave. The multiplier compares it with the first one so that its output stays locked to the crystal.

Two select pins choose the display format. The pins are sampled on every master cycle. The decoded format is applied only when a frame-boundary strobe is present, so a display never changes format in the middle of a frame. The decoded outputs are a flag for the 80-column family, a flag for double-width characters, and the column and row counts of the active format.

The divider on the returned clock runs entirely in that clock's domain. It takes its reset from a two-stage synchronizer fed by the master-domain reset.

Top module: `vref_clkgen`

## Requirements
- R1: While `rst` is high at a master clock edge, `dot_lo_o`, `pll_ref_o`, `fam80_o` and `dbl_width_o` go to 0, `cols_o` goes to 64 and `rows_o` goes to 16.
- R2: `dot_lo_o` is 1 in the first master cycle after reset is released, and then changes value on every master clock edge (master divided by 2).
- R3: `pll_ref_o` has a period of 16 master cycles. It is high for 8 cycles and then low for 8, and its first high phase starts in the first master cycle after reset.
- R4: `cmp_ref_o` has a period of 10 returned-clock cycles, high for 5 and then low for 5. It is held low while the reset seen through two returned-clock flops is active, and its first high phase starts on the first returned-clock edge after that.
- R5: The select pins are registered on every master edge. The decoded outputs load only on a master edge where `frame_stb_i` is 1, and they take the selection registered on the edge before. When the strobe is 0 they hold, whatever the select pins do.
- R6: The format code is {`mode_dbl_i`, `mode_wide_i`}: 00 gives 64 columns by 16 rows, 10 gives 32x16, 01 gives 80x24 and 11 gives 40x24. `fam80_o` follows the code's wide bit and `dbl_width_o` follows its double bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_mst | input | 1 | 20.2752 MHz master clock |
| rst | input | 1 | Synchronous active-high reset, master domain |
| clk_pll_i | input | 1 | 12.672 MHz clock returned from the external multiplier |
| mode_dbl_i | input | 1 | Format select: 1 selects double-width characters |
| mode_wide_i | input | 1 | Format select: 1 selects the 80/40-column family |
| frame_stb_i | input | 1 | Frame-boundary strobe that lets a new format take effect |
| dot_lo_o | output | 1 | 10.1376 MHz dot reference |
| pll_ref_o | output | 1 | 1.2672 MHz reference for the multiplier (master / 16) |
| cmp_ref_o | output | 1 | 1.2672 MHz comparison signal (returned clock / 10) |
| fam80_o | output | 1 | 80-column family active |
| dbl_width_o | output | 1 | Double-width characters active |
| cols_o | output | 7 | Characters per row in the active format |
| rows_o | output | 5 | Rows in the active format |

## Verification
On every cycle, the assertions check four things: the dot reference alternates; neither 1.2672 MHz signal stays at one level longer than half its period; the decoded outputs hold between strobes and, after a strobe, load the selection sampled one edge earlier; and the column and row counts agree with the two flags. Some behaviour can only be shown by the bench's reference model, which runs alongside the design in both clock domains. That covers the exact phase of each divider after reset, the comparison signal staying low for the synchronizer's latency, and the format loaded when the selection changes on the same edge as the strobe.

// File: rtl/vref_pkg.sv
`timescale 1ns/1ps
package vref_pkg;

    // Division ratios against the source clocks
    localparam int unsigned DOT_DIV     = 2;   // 20.2752 MHz -> 10.1376 MHz
    localparam int unsigned MST_REF_DIV = 16;  // 20.2752 MHz -> 1.2672 MHz
    localparam int unsigned PLL_CMP_DIV = 10;  // 12.672 MHz  -> 1.2672 MHz
    localparam int unsigned RST_STAGES  = 2;

    localparam int unsigned COL_W = 7;
    localparam int unsigned ROW_W = 5;

    localparam int unsigned COLS_NARROW = 64;
    localparam int unsigned COLS_WIDE   = 80;
    localparam int unsigned ROWS_NARROW = 16;
    localparam int unsigned ROWS_WIDE   = 24;

    // Code bit 1: double-width characters, bit 0: 80-column family
    typedef enum logic [1:0] {
        FMT_64X16 = 2'b00,
        FMT_80X24 = 2'b01,
        FMT_32X16 = 2'b10,
        FMT_40X24 = 2'b11
    } vfmt_e;

    typedef struct packed {
        logic             fam80;
        logic             dbl;
        logic [COL_W-1:0] cols;
        logic [ROW_W-1:0] rows;
    } vflags_t;

    function automatic vflags_t fmt_decode(input vfmt_e f);
        vflags_t r;
        r.fam80 = f[0];
        r.dbl   = f[1];
        unique case (f)
            FMT_64X16: begin r.cols = COL_W'(COLS_NARROW);     r.rows = ROW_W'(ROWS_NARROW); end
            FMT_32X16: begin r.cols = COL_W'(COLS_NARROW / 2); r.rows = ROW_W'(ROWS_NARROW); end
            FMT_80X24: begin r.cols = COL_W'(COLS_WIDE);       r.rows = ROW_W'(ROWS_WIDE);   end
            default:   begin r.cols = COL_W'(COLS_WIDE / 2);   r.rows = ROW_W'(ROWS_WIDE);   end
        endcase
        return r;
    endfunction

    localparam vflags_t FLAGS_RESET = fmt_decode(FMT_64X16);

endpackage

// File: rtl/vref_div.sv
`timescale 1ns/1ps
// Near-square divider: high for ceil(DIV/2) cycles, then low for the rest,
// first high cycle directly after reset.
module vref_div #(
    parameter int unsigned DIV = 16
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic out_o
);
    generate
        if (DIV == 2) begin : g_toggle
            logic q;
            always_ff @(posedge clk_i) begin
                if (rst_i) q <= 1'b0;
                else       q <= ~q;
            end
            assign out_o = q;
        end else begin : g_count
            localparam int unsigned CW = $clog2(DIV);
            localparam logic [CW-1:0] LAST = CW'(DIV - 1);
            localparam logic [CW-1:0] HI_N = CW'((DIV + 1) / 2);
            logic [CW-1:0] cnt;
            logic [CW-1:0] cnt_nxt;
            logic          q;
            always_comb cnt_nxt = (cnt == LAST) ? '0 : cnt + 1'b1;
            always_ff @(posedge clk_i) begin
                if (rst_i) begin
                    cnt <= LAST;
                    q   <= 1'b0;
                end else begin
                    cnt <= cnt_nxt;
                    q   <= (cnt_nxt < HI_N);
                end
            end
            assign out_o = q;
        end
    endgenerate
endmodule

// File: rtl/vref_rst_sync.sv
`timescale 1ns/1ps
module vref_rst_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_in_i,
    output logic rst_out_o
);
    logic [STAGES-1:0] sh = '1;
    always_ff @(posedge clk_i) sh <= {sh[STAGES-2:0], rst_in_i};
    assign rst_out_o = sh[STAGES-1];
endmodule

// File: rtl/vref_mode.sv
`timescale 1ns/1ps
module vref_mode
    import vref_pkg::*;
(
    input  logic    clk_i,
    input  logic    rst_i,
    input  logic    dbl_i,
    input  logic    wide_i,
    input  logic    stb_i,
    output vflags_t flags_o
);
    vfmt_e   sel_q;
    vflags_t flags_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sel_q   <= FMT_64X16;
            flags_q <= FLAGS_RESET;
        end else begin
            sel_q <= vfmt_e'({dbl_i, wide_i});
            if (stb_i) flags_q <= fmt_decode(sel_q);
        end
    end

    assign flags_o = flags_q;
endmodule

// File: rtl/vref_clkgen.sv
`timescale 1ns/1ps
module vref_clkgen
    import vref_pkg::*;
(
    input  logic             clk_mst,
    input  logic             rst,
    input  logic             clk_pll_i,
    input  logic             mode_dbl_i,
    input  logic             mode_wide_i,
    input  logic             frame_stb_i,
    output logic             dot_lo_o,
    output logic             pll_ref_o,
    output logic             cmp_ref_o,
    output logic             fam80_o,
    output logic             dbl_width_o,
    output logic [COL_W-1:0] cols_o,
    output logic [ROW_W-1:0] rows_o
);
    logic    pll_rst;
    vflags_t flags;

    vref_div #(.DIV(DOT_DIV)) u_dot (
        .clk_i(clk_mst), .rst_i(rst), .out_o(dot_lo_o)
    );

    vref_div #(.DIV(MST_REF_DIV)) u_mref (
        .clk_i(clk_mst), .rst_i(rst), .out_o(pll_ref_o)
    );

    vref_rst_sync #(.STAGES(RST_STAGES)) u_psync (
        .clk_i(clk_pll_i), .rst_in_i(rst), .rst_out_o(pll_rst)
    );

    vref_div #(.DIV(PLL_CMP_DIV)) u_pcmp (
        .clk_i(clk_pll_i), .rst_i(pll_rst), .out_o(cmp_ref_o)
    );

    vref_mode u_mode (
        .clk_i(clk_mst), .rst_i(rst),
        .dbl_i(mode_dbl_i), .wide_i(mode_wide_i), .stb_i(frame_stb_i),
        .flags_o(flags)
    );

    assign fam80_o     = flags.fam80;
    assign dbl_width_o = flags.dbl;
    assign cols_o      = flags.cols;
    assign rows_o      = flags.rows;
endmodule

// File: rtl/vref_chk.sv
`timescale 1ns/1ps
module vref_chk
    import vref_pkg::*;
(
    input logic             clk_mst,
    input logic             rst,
    input logic             clk_pll_i,
    input logic             pll_rst,
    input logic             mode_dbl_i,
    input logic             mode_wide_i,
    input logic             frame_stb_i,
    input logic             dot_lo_o,
    input logic             pll_ref_o,
    input logic             cmp_ref_o,
    input logic             fam80_o,
    input logic             dbl_width_o,
    input logic [COL_W-1:0] cols_o,
    input logic [ROW_W-1:0] rows_o
);
    localparam int unsigned MHALF = MST_REF_DIV / 2;
    localparam int unsigned PHALF = (PLL_CMP_DIV + 1) / 2;

    int unsigned mrun, prun;
    logic        mprev, pprev;

    always_ff @(posedge clk_mst) begin
        if (rst) begin
            mrun  <= 0;
            mprev <= 1'b0;
        end else begin
            mprev <= pll_ref_o;
            mrun  <= (pll_ref_o != mprev) ? 0 : mrun + 1;
        end
    end

    always_ff @(posedge clk_pll_i) begin
        if (pll_rst) begin
            prun  <= 0;
            pprev <= 1'b0;
        end else begin
            pprev <= cmp_ref_o;
            prun  <= (cmp_ref_o != pprev) ? 0 : prun + 1;
        end
    end

    AST_DOT_ALTERNATES: assert property (@(posedge clk_mst) disable iff (rst)
        1'b1 |=> dot_lo_o != $past(dot_lo_o)); // R2

    AST_MREF_HALF_PERIOD: assert property (@(posedge clk_mst) disable iff (rst)
        mrun < MHALF); // R3

    AST_PCMP_HALF_PERIOD: assert property (@(posedge clk_pll_i) disable iff (pll_rst)
        prun < PHALF); // R4

    AST_FLAGS_HOLD: assert property (@(posedge clk_mst) disable iff (rst)
        !frame_stb_i |=> $stable({fam80_o, dbl_width_o, cols_o, rows_o})); // R5

    AST_FLAGS_LOAD: assert property (@(posedge clk_mst) disable iff (rst)
        (frame_stb_i && !$past(rst)) |=>
            {dbl_width_o, fam80_o} == $past({mode_dbl_i, mode_wide_i}, 2)); // R5

    AST_DECODE_SHAPE: assert property (@(posedge clk_mst) disable iff (rst)
        1'b1 |-> (rows_o == (fam80_o ? ROW_W'(ROWS_WIDE) : ROW_W'(ROWS_NARROW))) &&
                 (cols_o == ((fam80_o ? COL_W'(COLS_WIDE) : COL_W'(COLS_NARROW)) >> dbl_width_o))); // R6
endmodule

bind vref_clkgen vref_chk u_chk (
    .clk_mst(clk_mst), .rst(rst), .clk_pll_i(clk_pll_i), .pll_rst(pll_rst),
    .mode_dbl_i(mode_dbl_i), .mode_wide_i(mode_wide_i), .frame_stb_i(frame_stb_i),
    .dot_lo_o(dot_lo_o), .pll_ref_o(pll_ref_o), .cmp_ref_o(cmp_ref_o),
    .fam80_o(fam80_o), .dbl_width_o(dbl_width_o), .cols_o(cols_o), .rows_o(rows_o)
);

// File: tb/vref_clkgen_tb_top.sv
`timescale 1ns/1ps
module vref_clkgen_tb_top;
    logic clk_mst = 1'b0;
    logic clk_pll = 1'b0;
    logic rst = 1'b1;
    logic mdbl = 1'b0, mwide = 1'b0, stb = 1'b0;
    logic dot, mref, pcmp, fam80, dblw;
    logic [6:0] cols;
    logic [4:0] rows;

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    always #2 clk_mst = ~clk_mst;           // 250 MHz
    initial begin
        #1 clk_pll = 1'b1;
        forever #3.2 clk_pll = ~clk_pll;    // 0.625 x master rate
    end

    vref_clkgen dut_i (
        .clk_mst(clk_mst), .rst(rst), .clk_pll_i(clk_pll),
        .mode_dbl_i(mdbl), .mode_wide_i(mwide), .frame_stb_i(stb),
        .dot_lo_o(dot), .pll_ref_o(mref), .cmp_ref_o(pcmp),
        .fam80_o(fam80), .dbl_width_o(dblw), .cols_o(cols), .rows_o(rows)
    );

    // ---- reference model, master domain ----
    int       mk = 0;        // master edges since reset release
    int       sel_m = 0;     // registered selection code {dbl, wide}
    int       act_m = 0;     // active format code
    always @(posedge clk_mst) begin
        if (rst) begin
            mk = 0; sel_m = 0; act_m = 0;
        end else begin
            mk++;
            if (stb) act_m = sel_m;
            sel_m = {30'd0, mdbl, mwide};
        end
    end

    // ---- reference model, returned-clock domain ----
    int rq[$] = '{1, 1};     // reset as seen through two flops
    int pk = 0;
    always @(posedge clk_pll) begin
        int hold;
        hold = rq.pop_front();
        rq.push_back(int'(rst));
        if (hold != 0) pk = 0;
        else pk++;
    end

    function automatic int exp_cols(int code);
        case (code)
            0: return 64;
            2: return 32;
            1: return 80;
            default: return 40;
        endcase
    endfunction

    function automatic int exp_rows(int code);
        return (code % 2 == 1) ? 24 : 16;
    endfunction

    task automatic chk(string req, string sig, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, sig, act, exp, $time);
        end
    endtask

    always @(negedge clk_mst) begin
        if (!done) begin
            chk(mk == 0 ? "R1" : "R2", "dot_lo", int'(dot), (mk > 0) ? int'(((mk - 1) % 2) < 1) : 0);
            chk(mk == 0 ? "R1" : "R3", "pll_ref", int'(mref), (mk > 0) ? int'(((mk - 1) % 16) < 8) : 0);
            chk("R5", "fam80", int'(fam80), act_m % 2);
            chk("R5", "dbl_width", int'(dblw), act_m / 2);
            chk("R6", "cols", int'(cols), exp_cols(act_m));
            chk("R6", "rows", int'(rows), exp_rows(act_m));
        end
    end

    always @(negedge clk_pll) begin
        if (!done)
            chk("R4", "cmp_ref", int'(pcmp), (pk > 0) ? int'(((pk - 1) % 10) < 5) : 0);
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk_mst);
    endtask

    task automatic sel(logic d, logic w);
        mdbl = d; mwide = w;
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        cyc(8);
        chk("R1", "cols_reset", int'(cols), 64);
        chk("R1", "rows_reset", int'(rows), 16);
        chk("R4", "cmp_ref_in_reset", int'(pcmp), 0);
        rst = 1'b0;
        cyc(40);
        // R6: 80x24
        sel(1'b0, 1'b1); cyc(3);
        stb = 1'b1; cyc(1); stb = 1'b0; cyc(5);
        chk("R6", "cols_80x24", int'(cols), 80);
        // R5: selection change on the strobe edge loads the older selection
        sel(1'b1, 1'b1); stb = 1'b1; cyc(1); stb = 1'b0; cyc(1);
        chk("R5", "cols_same_edge", int'(cols), 80);
        stb = 1'b1; cyc(1); stb = 1'b0; cyc(2);
        chk("R6", "cols_40x24", int'(cols), 40);
        // R5: selection changes without strobe are ignored
        sel(1'b1, 1'b0); cyc(7); sel(1'b0, 1'b0); cyc(7); sel(1'b1, 1'b0); cyc(7);
        chk("R5", "cols_no_strobe", int'(cols), 40);
        stb = 1'b1; cyc(1); stb = 1'b0; cyc(2);
        chk("R6", "cols_32x16", int'(cols), 32);
        // strobe held while selection moves
        stb = 1'b1;
        sel(1'b0, 1'b0); cyc(2); sel(1'b0, 1'b1); cyc(3); sel(1'b1, 1'b1); cyc(1);
        stb = 1'b0; cyc(10);
        // mid-run reset restarts both domains
        rst = 1'b1; cyc(3);
        chk("R1", "fam80_reset", int'(fam80), 0);
        rst = 1'b0; cyc(120);
        sel(1'b0, 1'b1); stb = 1'b1; cyc(2); stb = 1'b0; cyc(60);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk_mst);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end
endmodule